// File: doc/BRIEF.md
# Nested hardware loop sequencer

This unit chooses the next fetch address for a simple processor front end that supports two hardware loops with no branch instructions in the loop body. Each loop context holds a start address (the first instruction of the body), an end address (the last instruction of the body) and a repeat count. On each valid fetch the current PC is compared against both end addresses. If a matching loop still has a nonzero count, the next PC jumps back to that loop's start and the count drops by one. In every other case the PC advances by the instruction length, which is supplied as an input.

Software programs a loop in one of two ways. A compact setup command gives the loop index and two signed 10-bit halfword offsets, both relative to the PC of the setup command, and can load a count at the same time. The other way is a register-write port that updates one field of one loop. When both loops end on the same instruction, loop 1 acts as the inner loop: it gets the first chance to repeat, and loop 0 repeats only when loop 1 is exhausted. A count of N set before entry therefore gives N+1 passes of the body.

Top module: `hwloop_seq`

## Requirements
- R1: After reset, all six loop registers (start, end and count of loops 0 and 1) read zero.
- R2: When fetchValid is low, or the PC matches no loop end that has a nonzero count, nextPc equals pc plus instLen, in the same cycle.
- R3: When fetchValid is high, pc equals a loop's end address and that loop's count is nonzero, nextPc equals that loop's start address in the same cycle, and the count reads one less after the next clock edge.
- R4: A loop whose count is zero when its end address is fetched falls through to pc plus instLen, and its count stays at zero.
- R5: When both loops have the same end address and loop 1's count is nonzero, loop 1 is the one redirected and decremented, and loop 0's count does not change.
- R6: When both loops have the same end address, loop 1's count is zero and loop 0's count is nonzero, nextPc is loop 0's start and loop 0's count decrements.
- R7: A setup command (setupValid with setupIdx) sets the selected loop's start to pc + 2*signext(setupTopOfs) and its end to pc + 2*signext(setupBotOfs), using the pc of the setup cycle. Both values can be read after the next edge. The count is loaded from setupCnt only when setupLoadCnt is high and is otherwise left unchanged. The full offset range from -512 to +511 halfwords is honoured.
- R8: A register write (regWrEn) updates the field that regWrSel selects in loop regWrIdx after the next edge, with regWrSel encoded as 0 for start, 1 for end and 2 for count. The value regWrSel = 3 changes no register.
- R9: A register write to a count in the same cycle as that count's decrement leaves the written value. A register write in the same cycle as a setup command to the same field also leaves the written value.
- R10: A loop whose start equals its end repeats the single instruction: nextPc equals pc for each fetch while the count is nonzero, and falls through once the count reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pc | input | 32 | Address of the instruction being fetched |
| instLen | input | 3 | Length of the current instruction in bytes |
| fetchValid | input | 1 | Current fetch is valid |
| setupValid | input | 1 | Loop setup command present |
| setupIdx | input | 1 | Loop selected by the setup command |
| setupTopOfs | input | 10 | Signed halfword offset from pc to the loop start |
| setupBotOfs | input | 10 | Signed halfword offset from pc to the loop end |
| setupLoadCnt | input | 1 | Setup command also loads the count |
| setupCnt | input | 32 | Count value loaded by the setup command |
| regWrEn | input | 1 | Single register write strobe |
| regWrIdx | input | 1 | Loop selected by the register write |
| regWrSel | input | 2 | Field select: 0 start, 1 end, 2 count, 3 none |
| regWrData | input | 32 | Register write value |
| nextPc | output | 32 | Address of the next fetch |
| loop0Top | output | 32 | Loop 0 start address |
| loop0Bot | output | 32 | Loop 0 end address |
| loop0Cnt | output | 32 | Loop 0 count |
| loop1Top | output | 32 | Loop 1 start address |
| loop1Bot | output | 32 | Loop 1 end address |
| loop1Cnt | output | 32 | Loop 1 count |

## Verification
The bench runs a shared end address through three passes: inner repeats, then outer repeats, then both exhausted. A design with the priority reversed would jump to the outer start first, and a design that decremented both counts would drain loop 0 early. Setup commands are driven at the extreme positive and negative offsets, so missing sign extension or a missing halfword scale would place the start or end at the wrong address. Collisions between a write and a decrement, and between a write and a setup, would expose the wrong priority as a stale count. A single-instruction loop and a zero-count fetch of an end address would catch a design that wraps the count below zero or never redirects to pc itself.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  localparam int NLOOP = 2;
  localparam int IDX_W = $clog2(NLOOP);

  typedef enum logic [1:0] {
    SEL_TOP  = 2'd0,
    SEL_BOT  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NLOOP-1:0] dec;      // decrement this loop's count
    logic             redirect; // next PC comes from a loop start
    logic [IDX_W-1:0] sel;      // which loop start
  } loopStrb_t;
endpackage

// File: rtl/hwloop_ctl.sv
module hwloop_ctl
  import hwloop_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         fetchValid,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] botQ [NLOOP],
  input  logic [W-1:0] cntQ [NLOOP],
  output loopStrb_t    strb
);
  logic [NLOOP-1:0] cand;

  for (genvar i = 0; i < NLOOP; i++) begin : g_cmp
    assign cand[i] = fetchValid && (pc == botQ[i]) && (cntQ[i] != '0);
  end

  // higher index is the inner loop and wins a shared end address
  always_comb begin
    strb = '0;
    for (int i = 0; i < NLOOP; i++) begin
      if (cand[i]) begin
        strb.redirect = 1'b1;
        strb.sel      = IDX_W'(i);
      end
    end
    if (strb.redirect) strb.dec[strb.sel] = 1'b1;
  end
endmodule

// File: rtl/hwloop_dp.sv
module hwloop_dp
  import hwloop_pkg::*;
#(
  parameter int W     = 32,
  parameter int OFS_W = 10,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [W-1:0]     pc,
  input  logic [LEN_W-1:0] instLen,
  input  logic             setupValid,
  input  logic [IDX_W-1:0] setupIdx,
  input  logic [OFS_W-1:0] setupTopOfs,
  input  logic [OFS_W-1:0] setupBotOfs,
  input  logic             setupLoadCnt,
  input  logic [W-1:0]     setupCnt,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regWrIdx,
  input  logic [1:0]       regWrSel,
  input  logic [W-1:0]     regWrData,
  input  loopStrb_t        strb,
  output logic [W-1:0]     topQ [NLOOP],
  output logic [W-1:0]     botQ [NLOOP],
  output logic [W-1:0]     cntQ [NLOOP],
  output logic [W-1:0]     nextPc
);
  localparam int EXT_W = W - OFS_W - 1;

  logic [W-1:0] setupTop, setupBot;

  // signed halfword offsets: sign-extend and scale by two
  assign setupTop = pc + {{EXT_W{setupTopOfs[OFS_W-1]}}, setupTopOfs, 1'b0};
  assign setupBot = pc + {{EXT_W{setupBotOfs[OFS_W-1]}}, setupBotOfs, 1'b0};

  for (genvar i = 0; i < NLOOP; i++) begin : g_loop
    logic setupHit, wrHit;
    assign setupHit = setupValid && (setupIdx == IDX_W'(i));
    assign wrHit    = regWrEn && (regWrIdx == IDX_W'(i));

    // later assignments take priority: write > setup > decrement
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        topQ[i] <= '0;
        botQ[i] <= '0;
        cntQ[i] <= '0;
      end else begin
        if (strb.dec[i]) cntQ[i] <= cntQ[i] - 1'b1;
        if (setupHit) begin
          topQ[i] <= setupTop;
          botQ[i] <= setupBot;
          if (setupLoadCnt) cntQ[i] <= setupCnt;
        end
        if (wrHit) begin
          unique case (regSel_e'(regWrSel))
            SEL_TOP:  topQ[i] <= regWrData;
            SEL_BOT:  botQ[i] <= regWrData;
            SEL_CNT:  cntQ[i] <= regWrData;
            SEL_NONE: ;
          endcase
        end
      end
    end
  end

  assign nextPc = strb.redirect ? topQ[strb.sel] : pc + W'(instLen);
endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
  import hwloop_pkg::*;
#(
  parameter int W     = 32,
  parameter int OFS_W = 10,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [W-1:0]     pc,
  input  logic [LEN_W-1:0] instLen,
  input  logic             fetchValid,
  input  logic             setupValid,
  input  logic             setupIdx,
  input  logic [OFS_W-1:0] setupTopOfs,
  input  logic [OFS_W-1:0] setupBotOfs,
  input  logic             setupLoadCnt,
  input  logic [W-1:0]     setupCnt,
  input  logic             regWrEn,
  input  logic             regWrIdx,
  input  logic [1:0]       regWrSel,
  input  logic [W-1:0]     regWrData,
  output logic [W-1:0]     nextPc,
  output logic [W-1:0]     loop0Top,
  output logic [W-1:0]     loop0Bot,
  output logic [W-1:0]     loop0Cnt,
  output logic [W-1:0]     loop1Top,
  output logic [W-1:0]     loop1Bot,
  output logic [W-1:0]     loop1Cnt
);
  logic [W-1:0] topQ [NLOOP];
  logic [W-1:0] botQ [NLOOP];
  logic [W-1:0] cntQ [NLOOP];
  loopStrb_t    strb;

  hwloop_ctl #(.W(W)) i_ctl (
    .fetchValid(fetchValid), .pc(pc), .botQ(botQ), .cntQ(cntQ), .strb(strb)
  );

  hwloop_dp #(.W(W), .OFS_W(OFS_W), .LEN_W(LEN_W)) i_dp (
    .clk(clk), .rstN(rstN), .pc(pc), .instLen(instLen),
    .setupValid(setupValid), .setupIdx(setupIdx),
    .setupTopOfs(setupTopOfs), .setupBotOfs(setupBotOfs),
    .setupLoadCnt(setupLoadCnt), .setupCnt(setupCnt),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrSel(regWrSel),
    .regWrData(regWrData), .strb(strb),
    .topQ(topQ), .botQ(botQ), .cntQ(cntQ), .nextPc(nextPc)
  );

  assign loop0Top = topQ[0];
  assign loop0Bot = botQ[0];
  assign loop0Cnt = cntQ[0];
  assign loop1Top = topQ[1];
  assign loop1Bot = botQ[1];
  assign loop1Cnt = cntQ[1];
endmodule

// File: rtl/hwloop_seq_chk.sv
module hwloop_seq_chk #(
  parameter int W     = 32,
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [W-1:0]     pc,
  input logic [LEN_W-1:0] instLen,
  input logic             fetchValid,
  input logic             setupValid,
  input logic             regWrEn,
  input logic             regWrIdx,
  input logic [1:0]       regWrSel,
  input logic [W-1:0]     regWrData,
  input logic [W-1:0]     nextPc,
  input logic [W-1:0]     loop0Top,
  input logic [W-1:0]     loop0Bot,
  input logic [W-1:0]     loop0Cnt,
  input logic [W-1:0]     loop1Top,
  input logic [W-1:0]     loop1Bot,
  input logic [W-1:0]     loop1Cnt
);
  logic inHit, outHit;
  assign inHit  = fetchValid && (pc == loop1Bot) && (loop1Cnt != '0);
  assign outHit = fetchValid && (pc == loop0Bot) && (loop0Cnt != '0);

  AST_IDLE_FALLTHRU: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> nextPc == pc + W'(instLen)); // R2

  AST_INNER_TOP: assert property (@(posedge clk) disable iff (!rstN)
    inHit |-> nextPc == loop1Top); // R3

  AST_INNER_DEC: assert property (@(posedge clk) disable iff (!rstN)
    inHit && !regWrEn && !setupValid |=> loop1Cnt == $past(loop1Cnt) - 1'b1); // R3

  AST_OUTER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    inHit && (pc == loop0Bot) && !regWrEn && !setupValid |=> $stable(loop0Cnt)); // R5

  AST_OUTER_TOP: assert property (@(posedge clk) disable iff (!rstN)
    outHit && !inHit |-> nextPc == loop0Top); // R6

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !inHit && !outHit |-> nextPc == pc + W'(instLen)); // R4

  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && !regWrIdx && regWrSel == 2'd2 |=> loop0Cnt == $past(regWrData)); // R9
endmodule

bind hwloop_seq hwloop_seq_chk #(.W(W), .LEN_W(LEN_W)) i_chk (
  .clk(clk), .rstN(rstN), .pc(pc), .instLen(instLen), .fetchValid(fetchValid),
  .setupValid(setupValid), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
  .regWrSel(regWrSel), .regWrData(regWrData), .nextPc(nextPc),
  .loop0Top(loop0Top), .loop0Bot(loop0Bot), .loop0Cnt(loop0Cnt),
  .loop1Top(loop1Top), .loop1Bot(loop1Bot), .loop1Cnt(loop1Cnt)
);

// File: tb/test_hwloop_seq.sv
`timescale 1ns/1ps
module test_hwloop_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pc = '0;
  logic [2:0]  instLen = '0;
  logic        fetchValid = 1'b0;
  logic        setupValid = 1'b0;
  logic        setupIdx = 1'b0;
  logic [9:0]  setupTopOfs = '0;
  logic [9:0]  setupBotOfs = '0;
  logic        setupLoadCnt = 1'b0;
  logic [31:0] setupCnt = '0;
  logic        regWrEn = 1'b0;
  logic        regWrIdx = 1'b0;
  logic [1:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] nextPc, loop0Top, loop0Bot, loop0Cnt, loop1Top, loop1Bot, loop1Cnt;

  int nVec = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  hwloop_seq i_hwloop_seq (
    .clk(clk), .rstN(rstN), .pc(pc), .instLen(instLen), .fetchValid(fetchValid),
    .setupValid(setupValid), .setupIdx(setupIdx), .setupTopOfs(setupTopOfs),
    .setupBotOfs(setupBotOfs), .setupLoadCnt(setupLoadCnt), .setupCnt(setupCnt),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrSel(regWrSel), .regWrData(regWrData),
    .nextPc(nextPc), .loop0Top(loop0Top), .loop0Bot(loop0Bot), .loop0Cnt(loop0Cnt),
    .loop1Top(loop1Top), .loop1Bot(loop1Bot), .loop1Cnt(loop1Cnt)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [2:0]  len;
    logic        fetch;
    logic [31:0] expNext;
    logic [31:0] expC0;
    logic [31:0] expC1;
  } vec_t;

  // loop1: 0x100..0x110 count 1; loop0: 0x0F0..0x110 count 1
  localparam vec_t VECS [5] = '{
    '{32'h104, 3'd2, 1'b1, 32'h106, 32'd1, 32'd1},  // R2 no match
    '{32'h110, 3'd2, 1'b1, 32'h100, 32'd1, 32'd0},  // R5 inner first
    '{32'h110, 3'd2, 1'b1, 32'h0F0, 32'd0, 32'd0},  // R6 outer next
    '{32'h110, 3'd2, 1'b1, 32'h112, 32'd0, 32'd0},  // R4 both zero
    '{32'h110, 3'd4, 1'b0, 32'h114, 32'd0, 32'd0}   // R2 no fetch
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetchValid = 1'b0; setupValid = 1'b0; setupLoadCnt = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic wr(input logic idx, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); idle();
    regWrEn = 1'b1; regWrIdx = idx; regWrSel = sel; regWrData = d;
    @(posedge clk); #1;
  endtask

  task automatic fetch(input logic [31:0] a, input logic [2:0] len);
    @(negedge clk); idle();
    pc = a; instLen = len; fetchValid = 1'b1;
    #1;
  endtask

  initial begin
    #1_000_000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 loop0Top", loop0Top, 0); chk("R1 loop0Bot", loop0Bot, 0);
    chk("R1 loop0Cnt", loop0Cnt, 0); chk("R1 loop1Top", loop1Top, 0);
    chk("R1 loop1Bot", loop1Bot, 0); chk("R1 loop1Cnt", loop1Cnt, 0);
    @(negedge clk); rstN = 1'b1;

    wr(1'b1, 2'd0, 32'h100); wr(1'b1, 2'd1, 32'h110); wr(1'b1, 2'd2, 32'd1);
    wr(1'b0, 2'd0, 32'h0F0); wr(1'b0, 2'd1, 32'h110); wr(1'b0, 2'd2, 32'd1);
    chk("R8 loop1Top", loop1Top, 32'h100);
    chk("R8 loop0Bot", loop0Bot, 32'h110);

    for (int k = 0; k < 5; k++) begin
      @(negedge clk); idle();
      pc = VECS[k].pc; instLen = VECS[k].len; fetchValid = VECS[k].fetch;
      #1;
      chk($sformatf("R2-table nextPc v%0d", k), nextPc, VECS[k].expNext);
      @(posedge clk); #1;
      chk($sformatf("R3 cnt0 v%0d", k), loop0Cnt, VECS[k].expC0);
      chk($sformatf("R3 cnt1 v%0d", k), loop1Cnt, VECS[k].expC1);
    end

    // R7 setup, loop 0, mixed offsets, count load
    @(negedge clk); idle();
    pc = 32'h200; setupValid = 1'b1; setupIdx = 1'b0;
    setupTopOfs = 10'd2; setupBotOfs = 10'h3FD; setupLoadCnt = 1'b1; setupCnt = 32'd5;
    @(posedge clk); #1;
    chk("R7 top0", loop0Top, 32'h204);
    chk("R7 bot0 negative", loop0Bot, 32'h1FA);
    chk("R7 cnt0 loaded", loop0Cnt, 32'd5);

    // R7 setup, loop 1, extreme offsets, no count load
    wr(1'b1, 2'd2, 32'd6);
    @(negedge clk); idle();
    pc = 32'h1000; setupValid = 1'b1; setupIdx = 1'b1;
    setupTopOfs = 10'h1FF; setupBotOfs = 10'h200; setupLoadCnt = 1'b0; setupCnt = 32'd99;
    @(posedge clk); #1;
    chk("R7 top1 max", loop1Top, 32'h13FE);
    chk("R7 bot1 min", loop1Bot, 32'h0C00);
    chk("R7 cnt1 kept", loop1Cnt, 32'd6);

    // R10 single-instruction loop in loop 1
    wr(1'b1, 2'd0, 32'h300); wr(1'b1, 2'd1, 32'h300); wr(1'b1, 2'd2, 32'd2);
    fetch(32'h300, 3'd2); chk("R10 pass1", nextPc, 32'h300);
    @(posedge clk); #1;   chk("R10 cnt1", loop1Cnt, 32'd1);
    fetch(32'h300, 3'd2); chk("R10 pass2", nextPc, 32'h300);
    @(posedge clk); #1;   chk("R10 cnt0", loop1Cnt, 32'd0);
    fetch(32'h300, 3'd2); chk("R10 exit", nextPc, 32'h302);
    @(posedge clk); #1;   chk("R4 stays zero", loop1Cnt, 32'd0);

    // R9 write beats decrement on loop 0
    wr(1'b0, 2'd1, 32'h400); wr(1'b0, 2'd2, 32'd3);
    fetch(32'h400, 3'd2);
    regWrEn = 1'b1; regWrIdx = 1'b0; regWrSel = 2'd2; regWrData = 32'd9;
    #1;
    chk("R3 redirect top0", nextPc, 32'h204);
    @(posedge clk); #1;
    chk("R9 write over dec", loop0Cnt, 32'd9);

    // R9 write beats setup on loop 1 count
    @(negedge clk); idle();
    pc = 32'h800; setupValid = 1'b1; setupIdx = 1'b1;
    setupTopOfs = 10'd4; setupBotOfs = 10'd8; setupLoadCnt = 1'b1; setupCnt = 32'd7;
    regWrEn = 1'b1; regWrIdx = 1'b1; regWrSel = 2'd2; regWrData = 32'h55;
    @(posedge clk); #1;
    chk("R9 write over setup", loop1Cnt, 32'h55);
    chk("R7 top1 with write", loop1Top, 32'h808);
    chk("R7 bot1 with write", loop1Bot, 32'h810);

    // R8 select 3 changes nothing
    wr(1'b0, 2'd3, 32'hDEAD_BEEF);
    chk("R8 sel3 top0", loop0Top, 32'h204);
    chk("R8 sel3 bot0", loop0Bot, 32'h400);
    chk("R8 sel3 cnt0", loop0Cnt, 32'd9);

    @(negedge clk); idle();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule